// File: doc/BRIEF.md
# Vectored Prioritized Interrupt Controller

This block collects interrupt requests for a small 8-bit processor core from six sources and presents one of them to the CPU. Three external pins are synchronized and edge-detected. One pin raises a request on each edge, falling and rising, so it feeds two request lines. Two timer pulse inputs go straight into the request register. Each request bit is sticky: it stays set until the CPU takes that interrupt or software rewrites the request register.

A per-source enable mask and a global enable decide which pending bits may interrupt the CPU. A programmable priority code chooses the winner among the enabled bits. The block reports the winner as a program-memory vector address equal to twice the source index. When the CPU acknowledges, the winning bit is cleared and the global enable drops in that same cycle, which blocks further interrupts until software sets the enable again.

For polled operation, software leaves the sources masked and reads the request register through the register port. Bits keep latching while they are masked. Software can also overwrite the request register directly.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset, the request register, the enable mask, the global enable and the priority code are all zero, irq_pending is 0, and every register reads 0.
- R2: A falling edge on dual_in sets request bit 0, and a rising edge on dual_in sets request bit 3. The bit becomes visible on the third rising clock edge after the pin changes, because the pin passes through two synchronizer flops and an edge detector.
- R3: A falling edge on ref_in sets request bit 1, and a falling edge on aux_in sets request bit 2, with the same latency as R2. Rising edges on these two pins set nothing.
- R4: A one-cycle high on tmr0_pulse sets request bit 4 at the next clock edge, and a one-cycle high on tmr1_pulse sets request bit 5 at the next clock edge. Such a set always lands, even in a cycle with an acknowledge or a software write.
- R5: A request bit stays set while its enable or the global enable is off. It can be read at address 2.
- R6: irq_pending is 1 exactly when the global enable is set and at least one request bit has its enable bit set.
- R7: While irq_pending is 1, vector_addr equals 2 × the index of the winning request (0, 2, 4, 6, 8 or 10). While irq_pending is 0, vector_addr is 0.
- R8: The requests form three pairs: A = {0,1}, B = {2,3} and C = {4,5}. Inside a pair, the lower index wins. The priority code selects the order of the pairs: 0 gives A,B,C; 1 gives A,C,B; 2 gives B,A,C; 3 gives B,C,A; 4 gives C,A,B; 5 gives C,B,A. Any code from 6 to 63 behaves like code 0.
- R9: When int_ack is high while irq_pending is 1, the winning request bit and the global enable are cleared at that clock edge. The other request bits are unchanged, and irq_pending is 0 in the next cycle.
- R10: A write to address 2 replaces the request register with data bits 5:0, and request bits set by hardware in the same cycle are ORed in. An acknowledge in the same cycle does not clear a request bit, but it still clears the global enable.
- R11: If an acknowledge and a mask write that sets the global enable occur in the same cycle, the global enable ends up cleared. The per-source enables still take the written value.
- R12: Register map, written when reg_wr is high and read combinationally on reg_rdata. Address 0 holds the mask: bit 7 is the global enable, bits 5:0 are the per-source enables, and bit 6 is ignored and reads 0. Address 1 holds the 6-bit priority code in bits 5:0. Address 2 holds the request bits in bits 5:0. Address 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dual_in | input | 1 | External pin; its falling edge sets request 0 and its rising edge sets request 3 |
| ref_in | input | 1 | External pin; its falling edge sets request 1 |
| aux_in | input | 1 | External pin; its falling edge sets request 2 |
| tmr0_pulse | input | 1 | Timer 0 event pulse; sets request 4 |
| tmr1_pulse | input | 1 | Timer 1 event pulse; sets request 5 |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for reg_addr |
| irq_pending | output | 1 | An enabled request exists and the global enable is set |
| vector_addr | output | 8 | Vector address of the winning request |
| int_ack | input | 1 | CPU grant handshake |

## Verification
The hardest situations to reach from the ports are collisions within one clock cycle. The first is an acknowledge that lands in the same cycle as a software write to the mask or request register. The second is a timer set that lands in the same cycle as a request-register overwrite. The stimulus reaches them by raising int_ack, reg_wr and a timer pulse together on one falling edge and lowering them on the next, so that exactly one rising edge sees them. The priority orderings are told apart by loading request patterns that leave pairs empty, so that the codes that swap only the two lower-ranked pairs give different winners.

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl #(
  parameter int SYNC_STAGES = 2,
  parameter int VEC_W       = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dual_in,
  input  logic             ref_in,
  input  logic             aux_in,
  input  logic             tmr0_pulse,
  input  logic             tmr1_pulse,
  input  logic             reg_wr,
  input  logic [1:0]       reg_addr,
  input  logic [7:0]       reg_wdata,
  output logic [7:0]       reg_rdata,
  output logic             irq_pending,
  output logic [VEC_W-1:0] vector_addr,
  input  logic             int_ack
);
  localparam int NSRC = 6;
  localparam int NPIN = 3;
  localparam logic [1:0] A_MASK = 2'd0;
  localparam logic [1:0] A_PRIO = 2'd1;
  localparam logic [1:0] A_REQ  = 2'd2;

  logic [NPIN-1:0] pin_raw, pin_s, pin_d, pin_fall, pin_rise;
  logic [NSRC-1:0] req_q, en_q, hw_set, enabled, ack_clr;
  logic [5:0]      prio_q;
  logic            gie_q, ack_take, win_found;
  logic [2:0]      win_idx;
  logic            unused_bit;

  assign pin_raw    = {aux_in, ref_in, dual_in};
  assign unused_bit = reg_wdata[6];

  for (genvar p = 0; p < NPIN; p++) begin : g_pin
    logic [SYNC_STAGES-1:0] sync_q;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        sync_q   <= '1;
        pin_d[p] <= 1'b1;
      end else begin
        sync_q   <= {sync_q[SYNC_STAGES-2:0], pin_raw[p]};
        pin_d[p] <= sync_q[SYNC_STAGES-1];
      end
    end
    assign pin_s[p] = sync_q[SYNC_STAGES-1];
  end

  assign pin_fall = pin_d & ~pin_s;
  assign pin_rise = ~pin_d & pin_s;
  assign hw_set   = {tmr1_pulse, tmr0_pulse, pin_rise[0], pin_fall[2], pin_fall[1], pin_fall[0]};

  function automatic logic [1:0] pair_at(input logic [5:0] code, input int slot);
    logic [5:0] ord;
    case (code)
      6'd1:    ord = {2'd1, 2'd2, 2'd0};
      6'd2:    ord = {2'd2, 2'd0, 2'd1};
      6'd3:    ord = {2'd0, 2'd2, 2'd1};
      6'd4:    ord = {2'd1, 2'd0, 2'd2};
      6'd5:    ord = {2'd0, 2'd1, 2'd2};
      default: ord = {2'd2, 2'd1, 2'd0};
    endcase
    return ord[slot*2 +: 2];
  endfunction

  assign enabled = req_q & en_q & {NSRC{gie_q}};

  always_comb begin
    logic [2:0] src;
    win_found = 1'b0;
    win_idx   = '0;
    for (int pos = 0; pos < NSRC; pos++) begin
      src = {pair_at(prio_q, pos / 2), 1'b0} + 3'(pos % 2);
      if (!win_found && enabled[src]) begin
        win_found = 1'b1;
        win_idx   = src;
      end
    end
  end

  assign irq_pending = win_found;
  assign vector_addr = {{(VEC_W-4){1'b0}}, win_idx, 1'b0};
  assign ack_take    = int_ack & win_found;
  assign ack_clr     = ack_take ? (NSRC'(1) << win_idx) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_q  <= '0;
      en_q   <= '0;
      gie_q  <= 1'b0;
      prio_q <= '0;
    end else begin
      if (reg_wr && reg_addr == A_REQ) req_q <= reg_wdata[NSRC-1:0] | hw_set;
      else                             req_q <= (req_q & ~ack_clr) | hw_set;
      if (reg_wr && reg_addr == A_MASK) begin
        en_q  <= reg_wdata[NSRC-1:0];
        gie_q <= reg_wdata[7];
      end
      if (ack_take) gie_q <= 1'b0;
      if (reg_wr && reg_addr == A_PRIO) prio_q <= reg_wdata[5:0];
    end
  end

  always_comb begin
    case (reg_addr)
      A_MASK:  reg_rdata = {gie_q, 1'b0, en_q};
      A_PRIO:  reg_rdata = {2'b0, prio_q};
      A_REQ:   reg_rdata = {2'b0, req_q};
      default: reg_rdata = 8'h00;
    endcase
  end
endmodule

// File: rtl/irq_vector_ctrl_chk.sv
module irq_vector_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       int_ack,
  input logic       irq_pending,
  input logic [7:0] vector_addr,
  input logic       reg_wr,
  input logic [1:0] reg_addr,
  input logic       tmr0_pulse,
  input logic       tmr1_pulse,
  input logic [5:0] req_q,
  input logic [5:0] hw_set,
  input logic       gie_q
);
  logic wr_req;
  assign wr_req = reg_wr && reg_addr == 2'd2;

  assert_ack_drops_pending_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (int_ack && irq_pending) |=> !irq_pending);

  assert_ack_clears_winner_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (int_ack && irq_pending && !wr_req) |=>
      ((req_q & (6'd1 << $past(vector_addr[3:1])) & ~$past(hw_set)) == 6'd0));

  assert_timer0_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
    tmr0_pulse |=> req_q[4]);

  assert_timer1_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
    tmr1_pulse |=> req_q[5]);

  assert_vector_even_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pending |-> (vector_addr[0] == 1'b0 && vector_addr <= 8'd10));

  assert_bits_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_req && !int_ack) |=> ((req_q & $past(req_q)) == $past(req_q)));

  assert_gated_by_global_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !gie_q |-> !irq_pending);
endmodule

bind irq_vector_ctrl irq_vector_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .int_ack(int_ack), .irq_pending(irq_pending),
  .vector_addr(vector_addr), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .tmr0_pulse(tmr0_pulse), .tmr1_pulse(tmr1_pulse), .req_q(req_q),
  .hw_set(hw_set), .gie_q(gie_q)
);

// File: tb/tb_irq_vector_ctrl.sv
module tb_irq_vector_ctrl;
  logic clk = 0, rst_n = 0;
  logic dual_in = 1, ref_in = 1, aux_in = 1, tmr0_pulse = 0, tmr1_pulse = 0;
  logic reg_wr = 0, int_ack = 0;
  logic [1:0] reg_addr = 0;
  logic [7:0] reg_wdata = 0, reg_rdata, vector_addr;
  logic irq_pending;
  int n_checks = 0, n_errs = 0;
  bit done = 0;

  always #10 clk = ~clk;

  irq_vector_ctrl dut (
    .clk(clk), .rst_n(rst_n), .dual_in(dual_in), .ref_in(ref_in), .aux_in(aux_in),
    .tmr0_pulse(tmr0_pulse), .tmr1_pulse(tmr1_pulse), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_pending(irq_pending), .vector_addr(vector_addr), .int_ack(int_ack)
  );

  task automatic chk(input string rq, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errs++;
      $display("FAIL %s: actual %h expected %h", rq, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic ack_pulse();
    @(negedge clk); int_ack = 1;
    @(negedge clk); int_ack = 0;
  endtask

  task automatic test_reset();
    logic [7:0] v;
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), v); chk("R1 reg after reset", v, 8'h00);
    end
    chk("R1 irq_pending after reset", {7'b0, irq_pending}, 8'h00);
  endtask

  task automatic test_pins();
    logic [7:0] v;
    @(negedge clk); dual_in = 0;
    repeat (2) @(posedge clk); @(negedge clk);
    rd(2, v); chk("R2 no set before third edge", v, 8'h00);
    @(negedge clk); rd(2, v); chk("R2 falling dual sets bit0", v, 8'h01);
    dual_in = 1;
    repeat (3) @(negedge clk); rd(2, v); chk("R2 rising dual sets bit3", v, 8'h09);
    wr(2, 8'h00);
    ref_in = 0; repeat (3) @(negedge clk); rd(2, v); chk("R3 falling ref sets bit1", v, 8'h02);
    ref_in = 1; aux_in = 0; repeat (3) @(negedge clk); rd(2, v); chk("R3 falling aux sets bit2, ref rise none", v, 8'h06);
    aux_in = 1; repeat (3) @(negedge clk); rd(2, v); chk("R3 aux rise sets nothing", v, 8'h06);
    wr(2, 8'h00);
  endtask

  task automatic test_masked_poll();
    logic [7:0] v;
    @(negedge clk); tmr0_pulse = 1; @(negedge clk); tmr0_pulse = 0;
    rd(2, v); chk("R4 timer0 sets bit4", v, 8'h10);
    chk("R5 masked bit not pending", {7'b0, irq_pending}, 8'h00);
    @(negedge clk); tmr1_pulse = 1; @(negedge clk); tmr1_pulse = 0;
    rd(2, v); chk("R4 timer1 sets bit5", v, 8'h30);
    wr(0, 8'h10); #1;
    chk("R6 no pending without global enable", {7'b0, irq_pending}, 8'h00);
    rd(2, v); chk("R5 bits held while masked", v, 8'h30);
    wr(0, 8'hD0); rd(0, v); chk("R12 mask bit6 ignored", v, 8'h90);
    chk("R6 pending with enable", {7'b0, irq_pending}, 8'h01);
    chk("R7 vector for bit4", vector_addr, 8'd8);
    wr(0, 8'h00); wr(2, 8'h00);
    #1 chk("R7 vector zero when idle", vector_addr, 8'd0);
  endtask

  task automatic test_priority();
    logic [7:0] e_all [8] = '{0, 0, 4, 4, 8, 8, 0, 0};
    logic [7:0] e_odd [8] = '{2, 2, 6, 6, 10, 10, 2, 2};
    logic [7:0] e_mid [8] = '{4, 8, 4, 4, 8, 8, 4, 4};
    logic [7:0] v;
    wr(0, 8'hBF);
    wr(2, 8'h3F);
    for (int c = 0; c < 8; c++) begin
      wr(1, 8'(c)); #1 chk($sformatf("R8 all pending code %0d", c), vector_addr, e_all[c]);
    end
    wr(2, 8'h2A);
    for (int c = 0; c < 8; c++) begin
      wr(1, 8'(c)); #1 chk($sformatf("R8 odd pending code %0d", c), vector_addr, e_odd[c]);
    end
    wr(2, 8'h14);
    for (int c = 0; c < 8; c++) begin
      wr(1, 8'(c)); #1 chk($sformatf("R8 bits2,4 code %0d", c), vector_addr, e_mid[c]);
    end
    wr(1, 8'd63); #1 chk("R8 code 63 default", vector_addr, 8'd4);
    rd(1, v); chk("R12 priority readback", v, 8'd63);
    wr(1, 8'd0); wr(2, 8'h00); wr(0, 8'h00);
  endtask

  task automatic test_ack();
    logic [7:0] v;
    wr(2, 8'h3F); wr(0, 8'hBF);
    ack_pulse(); #1;
    rd(2, v); chk("R9 ack clears bit0 only", v, 8'h3E);
    rd(0, v); chk("R9 ack clears global enable", v, 8'h3F);
    chk("R9 no pending after ack", {7'b0, irq_pending}, 8'h00);
    wr(0, 8'hBF); #1 chk("R7 next winner bit1", vector_addr, 8'd2);
    wr(1, 8'd4); #1 chk("R8 code4 picks bit4", vector_addr, 8'd8);
    ack_pulse(); rd(2, v); chk("R9 ack clears bit4", v, 8'h2E);
    wr(0, 8'hBF);
    @(negedge clk); int_ack = 1; reg_wr = 1; reg_addr = 0; reg_wdata = 8'hBF;
    @(negedge clk); int_ack = 0; reg_wr = 0;
    rd(0, v); chk("R11 ack beats mask write", v, 8'h3F);
    rd(2, v); chk("R11 winner bit5 cleared", v, 8'h0E);
    wr(1, 8'd0);
  endtask

  task automatic test_sw_write();
    logic [7:0] v;
    @(negedge clk); reg_wr = 1; reg_addr = 2; reg_wdata = 8'h01; tmr1_pulse = 1;
    @(negedge clk); reg_wr = 0; tmr1_pulse = 0;
    rd(2, v); chk("R10 write merged with timer set", v, 8'h21);
    wr(0, 8'hBF);
    @(negedge clk); int_ack = 1; reg_wr = 1; reg_addr = 2; reg_wdata = 8'h3F;
    @(negedge clk); int_ack = 0; reg_wr = 0;
    rd(2, v); chk("R10 write wins over ack clear", v, 8'h3F);
    rd(0, v); chk("R10 ack still clears global enable", v, 8'h3F);
    rd(3, v); chk("R12 address 3 reads zero", v, 8'h00);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_errs++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    test_reset();
    test_pins();
    test_masked_poll();
    test_priority();
    test_ack();
    test_sw_write();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
    $finish;
  end
endmodule